// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block sits between a set of peripheral interrupt lines and a processor core. Each line is latched when its level rises, but only if that line's own enable bit is set. The block then competes every latched line against the others by a 3-bit priority, where 0 is the most urgent level, and asks the core for service. It presents the handler address of the winning line, looked up in an internal table. A master enable can silence every request without losing any latched line.

The core reports three events to the block:
- an acknowledge pulse when it enters the handler of the presented line;
- a clear pulse, with a line index, when a handler drops its latched flag;
- a return pulse when a handler exits.

The block keeps a stack of the priorities it has granted. A new request can interrupt a running handler only if its priority number is strictly below the one on top of the stack. A handler that returns without clearing its flag is requested again at once. The enable bits, priorities and handler table are loaded through simple indexed write ports. All state is cleared by a synchronous, active-high reset.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset, `pend_o`, `act_o`, `irq_o` and `depth_o` are all zero, and every enable bit, the master enable, every priority and every table entry is zero.
- R2: A line's pending bit (`pend_o[i]`) is set one cycle after `trig_i[i]` goes from 0 to 1, but only if enable bit i was already set in that cycle. A trigger that stays high does not set the bit later when the enable bit is written afterwards.
- R3: While the master enable is 0, `irq_o` stays 0, and latched pending bits are kept.
- R4: Among lines that are pending and enabled, the one with the smallest priority number is presented on `src_o`. On a tie, the lowest index wins. A pending line whose enable bit is 0 is not presented.
- R5: `vec_o` equals the table entry that was last written for the index shown on `src_o`.
- R6: An acknowledge while `irq_o` is 1 makes the presented line active (`act_o`) and raises `depth_o` by one. The line's pending bit stays set, giving the active-and-pending state. An acknowledge while `irq_o` is 0 has no effect.
- R7: A clear pulse with index i drops `pend_o[i]` in the next cycle. If line i rises with its enable set in the same cycle, the line stays pending.
- R8: A return pulse makes the most recently acknowledged line inactive and lowers `depth_o` by one. A return pulse when `depth_o` is 0 has no effect.
- R9: If a handler returns without clearing its flag, `irq_o` is 1 in the next cycle, presenting the same line again.
- R10: While a handler runs, a pending line is requested only if its priority number is strictly smaller than the priority on top of the stack. Equal or larger numbers wait.
- R11: If acknowledge and return arrive in the same cycle with a non-empty stack, only the return takes effect.
- R12: A trigger pulse lasting one clock cycle is latched and stays pending until it is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trig_i | input | NSRC | Trigger level of each line |
| master_we | input | 1 | Write strobe for the master enable |
| master_d | input | 1 | New master enable value |
| en_we | input | 1 | Write strobe for one line enable |
| en_idx | input | IW | Line index for the enable write |
| en_d | input | 1 | New enable value |
| pri_we | input | 1 | Write strobe for one priority |
| pri_idx | input | IW | Line index for the priority write |
| pri_d | input | 3 | New priority (0 most urgent) |
| vec_we | input | 1 | Write strobe for one table entry |
| vec_idx | input | IW | Line index for the table write |
| vec_d | input | VEC_W | New handler address |
| ack_i | input | 1 | Handler entry of the presented line |
| clr_i | input | 1 | Clear the pending flag of line `clr_idx` |
| clr_idx | input | IW | Line index for the clear |
| ret_i | input | 1 | Handler exit |
| irq_o | output | 1 | Service request to the core |
| vec_o | output | VEC_W | Handler address of the presented line |
| src_o | output | IW | Index of the presented line |
| pend_o | output | NSRC | Pending bit of each line |
| act_o | output | NSRC | Active bit of each line |
| depth_o | output | DW | Number of nested handlers |

## Verification
The hardest condition to reach is a deep nest: several handlers stacked with strictly decreasing priority numbers, while other lines wait at an equal number, and a return then arrives. Random pulses alone seldom build such a stack.

The directed phase builds it on purpose. It acknowledges a line at priority 4, then a tie at priority 3, then probes with an equal-priority line. It then returns with and without clearing, and issues an acknowledge and a return in the same cycle.

A long random phase with frequent acknowledges follows. A bench model of pending bits, active bits and the stack predicts every output in every cycle.

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl #(
  parameter int NSRC  = 8,
  parameter int VEC_W = 16,
  parameter int DEPTH = 8,
  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1,
  localparam int DW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NSRC-1:0]  trig_i,
  input  logic             master_we,
  input  logic             master_d,
  input  logic             en_we,
  input  logic [IW-1:0]    en_idx,
  input  logic             en_d,
  input  logic             pri_we,
  input  logic [IW-1:0]    pri_idx,
  input  logic [2:0]       pri_d,
  input  logic             vec_we,
  input  logic [IW-1:0]    vec_idx,
  input  logic [VEC_W-1:0] vec_d,
  input  logic             ack_i,
  input  logic             clr_i,
  input  logic [IW-1:0]    clr_idx,
  input  logic             ret_i,
  output logic             irq_o,
  output logic [VEC_W-1:0] vec_o,
  output logic [IW-1:0]    src_o,
  output logic [NSRC-1:0]  pend_o,
  output logic [NSRC-1:0]  act_o,
  output logic [DW-1:0]    depth_o
);
  localparam int SW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic             master_q;
  logic [NSRC-1:0]  en_q, pend_q, act_q, trig_q;
  logic [2:0]       pri_q [NSRC];
  logic [VEC_W-1:0] vec_q [NSRC];
  logic [2:0]       stk_pri [DEPTH];
  logic [IW-1:0]    stk_src [DEPTH];
  logic [DW-1:0]    depth_q;

  logic             found;
  logic [IW-1:0]    best_idx;
  logic [2:0]       best_pri;
  logic [SW-1:0]    top_ix;
  logic             empty, full, do_ret, do_ack;
  logic [NSRC-1:0]  rise;

  always_comb begin
    found    = 1'b0;
    best_idx = '0;
    best_pri = 3'd7;
    for (int i = 0; i < NSRC; i++) begin
      if (pend_q[i] && en_q[i] && (!found || pri_q[i] < best_pri)) begin
        found    = 1'b1;
        best_idx = IW'(i);
        best_pri = pri_q[i];
      end
    end
  end

  assign rise    = trig_i & ~trig_q;
  assign empty   = (depth_q == '0);
  assign full    = (depth_q == DW'(DEPTH));
  assign top_ix  = SW'(depth_q - DW'(1));
  assign irq_o   = master_q && found && (empty || best_pri < stk_pri[top_ix]);
  assign vec_o   = vec_q[best_idx];
  assign src_o   = best_idx;
  assign pend_o  = pend_q;
  assign act_o   = act_q;
  assign depth_o = depth_q;
  assign do_ret  = ret_i && !empty;
  assign do_ack  = ack_i && irq_o && !do_ret && !full;

  always_ff @(posedge clk) begin
    if (rst) begin
      master_q <= 1'b0;
      en_q     <= '0;
      pend_q   <= '0;
      act_q    <= '0;
      trig_q   <= '0;
      depth_q  <= '0;
      for (int i = 0; i < NSRC; i++) begin
        pri_q[i] <= '0;
        vec_q[i] <= '0;
      end
      for (int d = 0; d < DEPTH; d++) begin
        stk_pri[d] <= '0;
        stk_src[d] <= '0;
      end
    end else begin
      trig_q <= trig_i;
      if (master_we) master_q <= master_d;
      if (en_we)     en_q[en_idx] <= en_d;
      if (pri_we)    pri_q[pri_idx] <= pri_d;
      if (vec_we)    vec_q[vec_idx] <= vec_d;
      for (int i = 0; i < NSRC; i++) begin
        if (rise[i] && en_q[i])
          pend_q[i] <= 1'b1;
        else if (clr_i && clr_idx == IW'(i))
          pend_q[i] <= 1'b0;
      end
      if (do_ret) begin
        depth_q <= depth_q - DW'(1);
        act_q[stk_src[top_ix]] <= 1'b0;
      end else if (do_ack) begin
        stk_pri[SW'(depth_q)] <= best_pri;
        stk_src[SW'(depth_q)] <= best_idx;
        act_q[best_idx] <= 1'b1;
        depth_q <= depth_q + DW'(1);
      end
    end
  end

  // R6
  ack_grant_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_i && irq_o && empty) |=> (act_q[$past(src_o)] && depth_q == DW'(1)));

  // R8
  ret_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (ret_i && !empty) |=> (depth_q == $past(depth_q) - DW'(1)));

  // R10
  nest_order_chk: assert property (@(posedge clk) disable iff (rst)
    (depth_q >= DW'(2)) |-> (stk_pri[top_ix] < stk_pri[top_ix - SW'(1)]));

  // R3
  master_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (master_we && !master_d) |=> !irq_o);

  // R6
  depth_cap_chk: assert property (@(posedge clk) disable iff (rst)
    depth_q <= DW'(DEPTH));

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    // R2
    latch_rise_chk: assert property (@(posedge clk) disable iff (rst)
      (trig_i[g] && !trig_q[g] && en_q[g]) |=> pend_q[g]);
  end
endmodule

// File: tb/tb_nest_irq_ctrl.sv
module tb_nest_irq_ctrl;
  localparam int N = 8, VW = 16, D = 8, IW = 3, DW = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst;
  logic [N-1:0] trig;
  logic master_we, master_d, en_we, en_d, pri_we, vec_we, ack, clr, ret;
  logic [IW-1:0] en_idx, pri_idx, vec_idx, clr_idx;
  logic [2:0] pri_d;
  logic [VW-1:0] vec_d;
  logic irq;
  logic [VW-1:0] vec;
  logic [IW-1:0] src;
  logic [N-1:0] pend, act;
  logic [DW-1:0] depth;

  nest_irq_ctrl #(.NSRC(N), .VEC_W(VW), .DEPTH(D)) dut (
    .clk(clk), .rst(rst), .trig_i(trig),
    .master_we(master_we), .master_d(master_d),
    .en_we(en_we), .en_idx(en_idx), .en_d(en_d),
    .pri_we(pri_we), .pri_idx(pri_idx), .pri_d(pri_d),
    .vec_we(vec_we), .vec_idx(vec_idx), .vec_d(vec_d),
    .ack_i(ack), .clr_i(clr), .clr_idx(clr_idx), .ret_i(ret),
    .irq_o(irq), .vec_o(vec), .src_o(src), .pend_o(pend), .act_o(act), .depth_o(depth));

  int total = 0, bad = 0;
  bit [N-1:0] m_pend, m_act, m_en, m_trq;
  bit m_master;
  bit [2:0] m_pri [N];
  bit [VW-1:0] m_vec [N];
  bit [2:0] s_pri [D];
  bit [IW-1:0] s_src [D];
  int m_depth;

  function automatic int m_win(output bit f);
    int idx = 0;
    f = 0;
    for (int i = 0; i < N; i++)
      if (m_pend[i] && m_en[i] && (!f || m_pri[i] < m_pri[idx])) begin f = 1; idx = i; end
    return idx;
  endfunction

  function automatic bit m_irq();
    bit f;
    int w = m_win(f);
    return m_master && f && (m_depth == 0 || m_pri[w] < s_pri[m_depth-1]);
  endfunction

  task automatic chk(input string tag, input logic [31:0] a, input logic [31:0] e);
    total++;
    if (a !== e) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, a, e);
    end
  endtask

  task automatic compare(input string tag);
    bit f;
    int w = m_win(f);
    chk({tag, " irq"}, 32'(irq), 32'(m_irq()));
    if (m_irq()) begin
      chk({tag, " src"}, 32'(src), 32'(w));
      chk({tag, " vec"}, 32'(vec), 32'(m_vec[w]));
    end
    chk({tag, " pend"}, 32'(pend), 32'(m_pend));
    chk({tag, " act"}, 32'(act), 32'(m_act));
    chk({tag, " depth"}, 32'(depth), 32'(m_depth));
  endtask

  task automatic quiet();
    master_we = 0; en_we = 0; pri_we = 0; vec_we = 0;
    ack = 0; clr = 0; ret = 0;
  endtask

  task automatic step();
    bit f;
    int w = m_win(f);
    bit ie = m_irq();
    bit dr = ret && m_depth > 0;
    bit da = ack && ie && !dr && m_depth < D;
    bit [N-1:0] rs = trig & ~m_trq;
    for (int i = 0; i < N; i++) begin
      if (rs[i] && m_en[i]) m_pend[i] = 1;
      else if (clr && clr_idx == IW'(i)) m_pend[i] = 0;
    end
    if (dr) begin m_depth--; m_act[s_src[m_depth]] = 0; end
    else if (da) begin s_pri[m_depth] = m_pri[w]; s_src[m_depth] = IW'(w); m_act[w] = 1; m_depth++; end
    if (master_we) m_master = master_d;
    if (en_we) m_en[en_idx] = en_d;
    if (pri_we) m_pri[pri_idx] = pri_d;
    if (vec_we) m_vec[vec_idx] = vec_d;
    m_trq = trig;
    @(negedge clk);
    quiet();
  endtask

  task automatic pulse(input int i);
    trig[i] = 1; step(); trig[i] = 0; step();
  endtask

  initial begin
    #(20 * 200000);
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit [2:0] pr [N] = '{3'd6, 3'd3, 3'd3, 3'd4, 3'd0, 3'd5, 3'd7, 3'd2};
    void'($urandom(32'd7041));
    quiet(); trig = '0; en_idx = 0; en_d = 0; pri_idx = 0; pri_d = 0;
    vec_idx = 0; vec_d = 0; clr_idx = 0; master_d = 0;
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    m_pend = 0; m_act = 0; m_en = 0; m_trq = 0; m_master = 0; m_depth = 0;
    for (int i = 0; i < N; i++) begin m_pri[i] = 0; m_vec[i] = 0; end
    compare("R1");
    chk("R1 irq low", 32'(irq), 0);

    for (int i = 0; i < N; i++) begin
      pri_we = 1; pri_idx = IW'(i); pri_d = pr[i];
      vec_we = 1; vec_idx = IW'(i); vec_d = VW'(16'hA000 + i * 16);
      en_we = (i != 5); en_idx = IW'(i); en_d = 1;
      step();
    end
    master_we = 1; master_d = 1; step();

    pulse(5);
    chk("R2 disabled rise ignored", 32'(pend[5]), 0);
    trig[5] = 1; step();
    en_we = 1; en_idx = 5; en_d = 1; step(); step();
    chk("R2 held trigger after enable", 32'(pend[5]), 0);
    trig[5] = 0; step();

    pulse(3);
    chk("R12 one-cycle pulse latched", 32'(pend[3]), 1);
    chk("R5 vector of line 3", 32'(vec), 32'h00A030);
    compare("R4 R5");
    ack = 1; step();
    chk("R6 active and pending act", 32'(act[3]), 1);
    chk("R6 active and pending pend", 32'(pend[3]), 1);
    chk("R10 self level blocks", 32'(irq), 0);
    trig[1] = 1; trig[2] = 1; step(); trig = '0; step();
    chk("R4 tie lower index", 32'(src), 1);
    chk("R10 strictly higher preempts", 32'(irq), 1);
    ack = 1; step();
    chk("R10 equal priority waits", 32'(irq), 0);
    compare("R10");
    clr = 1; clr_idx = 1; step();
    chk("R7 clear drops pend", 32'(pend[1]), 0);
    ret = 1; step();
    chk("R8 return pops line 1", 32'(act[1]), 0);
    chk("R8 depth after pop", 32'(depth), 1);
    chk("R8 line 2 now requested", 32'(src), 2);
    ack = 1; step();
    ret = 1; step();
    chk("R9 uncleared line re-requested", 32'(irq), 1);
    chk("R9 same line", 32'(src), 2);
    ack = 1; ret = 1; step();
    chk("R11 return wins depth", 32'(depth), 0);
    chk("R11 ack ignored", 32'(act[2]), 0);
    master_we = 1; master_d = 0; step();
    chk("R3 master off silences", 32'(irq), 0);
    chk("R3 pending kept", 32'(pend[2]), 1);
    ack = 1; step();
    chk("R6 ack without request ignored", 32'(depth), 0);
    ret = 1; step();
    chk("R8 return on empty stack ignored", 32'(depth), 0);
    trig[0] = 1; clr = 1; clr_idx = 0; step(); trig[0] = 0; step();
    chk("R7 rise beats clear", 32'(pend[0]), 1);
    en_we = 1; en_idx = 2; en_d = 0; master_we = 1; master_d = 1; step();
    chk("R4 disabled line not presented", 32'(src), 3);
    compare("R3 R4 R7");
    en_we = 1; en_idx = 2; en_d = 1; step();

    for (int c = 0; c < 4000; c++) begin
      for (int i = 0; i < N; i++) if ($urandom_range(9) == 0) trig[i] = ~trig[i];
      ack = ($urandom_range(3) == 0);
      ret = ($urandom_range(4) == 0);
      clr = ($urandom_range(3) == 0); clr_idx = IW'($urandom_range(N-1));
      if ($urandom_range(40) == 0) begin en_we = 1; en_idx = IW'($urandom_range(N-1)); en_d = ($urandom_range(3) != 0); end
      if ($urandom_range(60) == 0) begin master_we = 1; master_d = ($urandom_range(4) != 0); end
      if (m_depth == 0 && $urandom_range(30) == 0) begin pri_we = 1; pri_idx = IW'($urandom_range(N-1)); pri_d = 3'($urandom_range(7)); end
      if ($urandom_range(30) == 0) begin vec_we = 1; vec_idx = IW'($urandom_range(N-1)); vec_d = VW'($urandom); end
      step();
      compare("R2 R4 R5 R6 R7 R8 R9 R10 R11 R12 random");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule